// File: doc/BRIEF.md
# Amplifier Control Register Target on a Two-Wire Serial Bus

This block is a two-wire (I2C) bus target that holds the three byte-wide control registers of an audio power amplifier. It oversamples SCL and SDA with a fast system clock, finds START and STOP conditions, matches its device address and acknowledges each byte. It pulls SDA low through an open-drain enable and never drives it high. The decoded control fields leave the block as parallel outputs that the analog amplifier settings read directly.

A write names a sub-address and then carries one or more data bytes. The low nibble of the sub-address selects the register. When the high nibble is zero, the index steps forward after every data byte. A read needs no sub-address. It always streams the registers from index 0 upward, for as long as the bus controller keeps acknowledging. An active-low shutdown input holds every register at zero.

Top module: `ampctl_i2c_target`

## Requirements
- R1: The target answers only to 7-bit device address 0x5B, which gives the address byte 0xB6 for a write and 0xB7 for a read. It acknowledges by pulling SDA low during the ninth SCL pulse. Any other address gets no acknowledge, and every byte after it is ignored until the next START.
- R2: In a write, the address byte, the sub-address byte and every data byte are each acknowledged. The first data byte goes into the register selected by sub-address bits 3:0.
- R3: When sub-address bits 7:4 are zero, the register index rises by one after each data byte, so consecutive data bytes fill consecutive registers.
- R4: When sub-address bits 7:4 are nonzero, the index does not advance, and every data byte of that transfer rewrites the same register.
- R5: Data bytes aimed at an index of 3 or more are acknowledged but change no register. Auto-increment past index 2 does not wrap back to index 0.
- R6: After the read address byte, the target sends register 0, then 1, then 2, most significant bit first, and then wraps to register 0 while the controller keeps acknowledging. A controller NACK ends the read, and SDA is released.
- R7: Bit 0 of register 0 always reads and acts as 0, whatever value is written to it.
- R8: While the shutdown input is low, all registers read 0 and writes have no effect. After shutdown is released the registers stay at 0 until they are rewritten.
- R9: Output mapping. From register 0: bit 1 drives `stby_off` (1 = standby released), bit 2 drives `spk_on` (1 = speaker save off), bit 3 drives `agc_en`, bit 6 drives `agc_track` and bit 7 drives `gain_boost`. From register 1: bits 1:0 drive `agc_attack`, bits 4:2 drive `agc_recover` and bits 7:5 drive `agc_level`. Register 2 drives `test_word`.
- R10: A START or STOP in the middle of a byte abandons that byte without writing it. A repeated START begins a new address phase.
- R11: The target controls SDA only through `sda_oe` (1 = pull low). `sda_oe` changes only while SCL is low.
- R12: After reset, all registers and decoded outputs are 0 and `sda_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| shdn_n | input | 1 | Active-low shutdown; clears all registers |
| stby_off | output | 1 | Standby released |
| spk_on | output | 1 | Speaker output active (save off) |
| agc_en | output | 1 | Automatic gain control enabled |
| agc_track | output | 1 | Supply-dependent limiter level enabled |
| gain_boost | output | 1 | Higher gain step selected |
| agc_attack | output | 2 | Attack time code |
| agc_recover | output | 3 | Recovery time code |
| agc_level | output | 3 | Limiter on-level code |
| test_word | output | 8 | Contents of the test register |

## Verification
The bench uses the default parameters: device address 0x5B, three registers and a two-flop synchronizer. With three registers, a four-byte read reaches the wrap from register 2 back to register 0. Auto-increment from sub-address 0x02 runs off the end of the register file, which exercises the discard path. Because the synchronizer is short, a bench SCL phase of 40 system clocks leaves ample margin between SDA updates and SCL edges. That margin is what allows the bench to check that SDA moves only while SCL is low.

// File: rtl/ampctl_pkg.sv
package ampctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVADR,
    ST_SUBADR,
    ST_WDATA,
    ST_RDATA
  } bus_st_e;

  // bit 0 of register 0 is not storable
  localparam logic [7:0] REG0_KEEP = 8'hFE;
endpackage

// File: rtl/ampctl_sync.sv
module ampctl_sync #(
  parameter int                 WIDTH   = 3,
  parameter int                 STAGES  = 2,
  parameter logic [WIDTH-1:0]   RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
    else        pipe_q <= {pipe_q[STAGES-2:0], din};
  end

  assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/ampctl_busevt.sv
module ampctl_busevt (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/ampctl_regs.sv
module ampctl_regs
  import ampctl_pkg::*;
#(
  parameter int NUM_REGS = 3,
  parameter int IDX_W    = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [7:0]                  wr_data,
  output logic [NUM_REGS-1:0][7:0]    regs_o
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    localparam logic [7:0] KEEP = (r == 0) ? REG0_KEEP : 8'hFF;
    logic [7:0] val_q;
    logic       hit;

    assign hit = wr_en && (wr_idx == IDX_W'(r));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val_q <= '0;
      else if (clr) val_q <= '0;
      else if (hit) val_q <= wr_data & KEEP;
    end

    assign regs_o[r] = val_q;
  end

  // R8: shutdown forces every register to zero
  a_r8_shutdown_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (regs_o == '0));

  // R5: a write beyond the register file leaves all registers untouched
  a_r5_range_discard: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr && (int'(wr_idx) >= NUM_REGS)) |=> $stable(regs_o));
endmodule

// File: rtl/ampctl_i2c_target.sv
module ampctl_i2c_target
  import ampctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h5B,
  parameter int         NUM_REGS    = 3,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       shdn_n,
  output logic       stby_off,
  output logic       spk_on,
  output logic       agc_en,
  output logic       agc_track,
  output logic       gain_boost,
  output logic [1:0] agc_attack,
  output logic [2:0] agc_recover,
  output logic [2:0] agc_level,
  output logic [7:0] test_word
);
  localparam int IDX_W  = 4;
  localparam int CNT_W  = 4;
  localparam int RPTR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(7);
  localparam logic [CNT_W-1:0] BIT_ACK  = CNT_W'(8);
  localparam logic [CNT_W-1:0] BIT_DONE = CNT_W'(9);

  logic [2:0] pins_s;
  logic scl_s, sda_s, shdn_s;
  logic scl_rise, scl_fall, start_det, stop_det;

  ampctl_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({shdn_n, sda_i, scl_i}),
    .dout (pins_s)
  );
  assign {shdn_s, sda_s, scl_s} = pins_s;

  ampctl_busevt u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  bus_st_e           st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [7:0]        sh_q, sh_d;
  logic              ack_q, ack_d, rnw_q, rnw_d, ainc_q, ainc_d;
  logic              mack_q, mack_d, oe_q, oe_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [RPTR_W-1:0] rptr_q, rptr_d, rsel, rnext;
  logic              wr_en;
  logic [7:0]        byte_in;
  logic [NUM_REGS-1:0][7:0] regs_w;

  assign byte_in = {sh_q[6:0], sda_s};
  assign rsel    = (st_q == ST_DEVADR) ? '0 : rptr_q;
  assign rnext   = (int'(rsel) == NUM_REGS - 1) ? '0 : rsel + 1'b1;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    ack_d  = ack_q;
    rnw_d  = rnw_q;
    ainc_d = ainc_q;
    mack_d = mack_q;
    oe_d   = oe_q;
    idx_d  = idx_q;
    rptr_d = rptr_q;
    wr_en  = 1'b0;
    if (start_det) begin
      st_d  = ST_DEVADR;
      cnt_d = '0;
      ack_d = 1'b0;
      oe_d  = 1'b0;
    end else if (stop_det) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
      oe_d  = 1'b0;
    end else if (st_q != ST_IDLE) begin
      if (scl_rise) begin
        if (cnt_q != BIT_DONE) cnt_d = cnt_q + 1'b1;
        if (st_q == ST_RDATA) begin
          if (cnt_q == BIT_ACK) mack_d = ~sda_s;
        end else if (cnt_q < BIT_ACK) begin
          sh_d = byte_in;
          if (cnt_q == BIT_LAST) begin
            case (st_q)
              ST_DEVADR: begin
                if (byte_in[7:1] == DEV_ADDR) begin
                  ack_d = 1'b1;
                  rnw_d = byte_in[0];
                end else begin
                  st_d = ST_IDLE;
                end
              end
              ST_SUBADR: begin
                idx_d  = byte_in[IDX_W-1:0];
                ainc_d = (byte_in[7:4] == 4'h0);
                ack_d  = 1'b1;
              end
              default: begin
                wr_en = 1'b1;
                ack_d = 1'b1;
              end
            endcase
          end
        end
      end else if (scl_fall) begin
        if (st_q == ST_RDATA) begin
          if (cnt_q != '0 && cnt_q < BIT_ACK) begin
            sh_d = {sh_q[6:0], sh_q[7]};
            oe_d = ~sh_q[6];
          end else if (cnt_q == BIT_ACK) begin
            oe_d = 1'b0;
          end else if (cnt_q == BIT_DONE) begin
            cnt_d = '0;
            if (mack_q) begin
              sh_d   = regs_w[rsel];
              oe_d   = ~regs_w[rsel][7];
              rptr_d = rnext;
            end else begin
              st_d = ST_IDLE;
              oe_d = 1'b0;
            end
          end
        end else if (cnt_q == BIT_ACK) begin
          oe_d = ack_q;
        end else if (cnt_q == BIT_DONE) begin
          oe_d  = 1'b0;
          cnt_d = '0;
          ack_d = 1'b0;
          case (st_q)
            ST_DEVADR: begin
              if (rnw_q) begin
                st_d   = ST_RDATA;
                sh_d   = regs_w[rsel];
                oe_d   = ~regs_w[rsel][7];
                rptr_d = rnext;
              end else begin
                st_d = ST_SUBADR;
              end
            end
            ST_SUBADR: st_d = ST_WDATA;
            default: begin
              if (ainc_q && idx_q != '1) idx_d = idx_q + 1'b1;
            end
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      ack_q  <= 1'b0;
      rnw_q  <= 1'b0;
      ainc_q <= 1'b0;
      mack_q <= 1'b0;
      oe_q   <= 1'b0;
      idx_q  <= '0;
      rptr_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      ack_q  <= ack_d;
      rnw_q  <= rnw_d;
      ainc_q <= ainc_d;
      mack_q <= mack_d;
      oe_q   <= oe_d;
      idx_q  <= idx_d;
      rptr_q <= rptr_d;
    end
  end

  ampctl_regs #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (~shdn_s),
    .wr_en  (wr_en),
    .wr_idx (idx_q),
    .wr_data(byte_in),
    .regs_o (regs_w)
  );

  assign sda_oe      = oe_q;
  assign stby_off    = regs_w[0][1];
  assign spk_on      = regs_w[0][2];
  assign agc_en      = regs_w[0][3];
  assign agc_track   = regs_w[0][6];
  assign gain_boost  = regs_w[0][7];
  assign agc_attack  = regs_w[1][1:0];
  assign agc_recover = regs_w[1][4:2];
  assign agc_level   = regs_w[1][7:5];
  assign test_word   = regs_w[2];

  // R11: the pull-down enable moves only while synchronized SCL is low
  a_r11_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> !scl_s);

  // R1: an idle target (unmatched or finished) never pulls SDA
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !oe_q);

  // R6: the read pointer stays inside the register file
  a_r6_rptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rptr_q) < NUM_REGS);

  // R2: each received data byte produces exactly one write strobe
  a_r2_write_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
endmodule

// File: tb/ampctl_i2c_target_test.sv
module ampctl_i2c_target_test;
  localparam int Q = 40;

  logic clk = 1'b0;
  logic rst_n;
  logic scl_m, sda_m, shdn_n;
  logic sda_oe, sda_line;
  logic stby_off, spk_on, agc_en, agc_track, gain_boost;
  logic [1:0] agc_attack;
  logic [2:0] agc_recover, agc_level;
  logic [7:0] test_word;

  int checks = 0;
  int fails  = 0;
  int viol   = 0;
  logic [7:0] exp_v[$];
  string      exp_r[$];
  logic [7:0] mon_val;
  event       mon_ev;
  logic       prev_oe;

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  ampctl_i2c_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .shdn_n(shdn_n), .stby_off(stby_off), .spk_on(spk_on), .agc_en(agc_en),
    .agc_track(agc_track), .gain_boost(gain_boost), .agc_attack(agc_attack),
    .agc_recover(agc_recover), .agc_level(agc_level), .test_word(test_word)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops expected items as the bus yields observed bytes / ack levels
  initial begin
    forever begin
      @(mon_ev);
      checks++;
      if (exp_v.size() == 0) begin
        fails++;
        $display("FAIL unexpected item: actual %0h expected none", mon_val);
      end else begin
        logic [7:0] e;
        string r;
        e = exp_v.pop_front();
        r = exp_r.pop_front();
        if (mon_val !== e) begin
          fails++;
          $display("FAIL %s: actual %0h expected %0h", r, mon_val, e);
        end
      end
    end
  end

  // R11 observer: SDA pull-down only changes while the bus SCL is low
  always @(negedge clk) begin
    if (rst_n && (sda_oe !== prev_oe) && scl_m) viol++;
    prev_oe <= sda_oe;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic wq();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic push_exp(input logic [7:0] v, input string req);
    exp_v.push_back(v);
    exp_r.push_back(req);
  endtask

  task automatic observe(input logic [7:0] v);
    mon_val = v;
    -> mon_ev;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wq();
    scl_m = 1'b1; wq(); wq();
    scl_m = 1'b0; wq();
  endtask

  // exp_line: expected SDA level in the ninth slot (0 = ACK)
  task automatic send_byte(input logic [7:0] b, input logic exp_line, input string req);
    logic lvl;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    push_exp({7'b0, exp_line}, req);
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    lvl = sda_line;
    observe({7'b0, lvl});
    wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic recv_byte(input bit mack, input logic [7:0] expv, input string req);
    logic [7:0] v;
    v = '0;
    push_exp(expv, req);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wq();
      scl_m = 1'b1; wq();
      v[i] = sda_line;
      wq();
      scl_m = 1'b0; wq();
    end
    observe(v);
    send_bit(~mack);
    sda_m = 1'b1;
  endtask

  task automatic write_regs(input logic [7:0] sub, input logic [7:0] d0, input logic [7:0] d1,
                            input logic [7:0] d2, input int n, input string req);
    bus_start();
    send_byte(8'hB6, 1'b0, "R1 write address ack");
    send_byte(sub, 1'b0, req);
    if (n > 0) send_byte(d0, 1'b0, req);
    if (n > 1) send_byte(d1, 1'b0, req);
    if (n > 2) send_byte(d2, 1'b0, req);
    bus_stop();
    wq();
  endtask

  task automatic read_regs(input logic [7:0] e0, input logic [7:0] e1, input logic [7:0] e2,
                           input logic [7:0] e3, input int n, input string req);
    bus_start();
    send_byte(8'hB7, 1'b0, "R1 read address ack");
    if (n > 0) recv_byte(n > 1, e0, req);
    if (n > 1) recv_byte(n > 2, e1, req);
    if (n > 2) recv_byte(n > 3, e2, req);
    if (n > 3) recv_byte(1'b0, e3, req);
    check(sda_oe == 1'b0, "R6 release after NACK", 32'(sda_oe), 0);
    bus_stop();
    wq();
  endtask

  initial begin
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; shdn_n = 1'b1; prev_oe = 1'b0;
    repeat (10) @(posedge clk);
    #1 rst_n = 1'b1;
    wq();

    // R12: reset state
    check(sda_oe == 1'b0, "R12 sda_oe", 32'(sda_oe), 0);
    check({stby_off, spk_on, agc_en, agc_track, gain_boost} == 5'b0, "R12 reg0 fields",
          32'({stby_off, spk_on, agc_en, agc_track, gain_boost}), 0);
    check({agc_attack, agc_recover, agc_level, test_word} == '0, "R12 reg1/reg2 fields",
          32'({agc_attack, agc_recover, agc_level, test_word}), 0);

    // R2/R3: auto-increment write of all three registers
    write_regs(8'h00, 8'hFF, 8'hA5, 8'h3C, 3, "R3 auto-increment ack");
    check({stby_off, spk_on, agc_en, agc_track, gain_boost} == 5'b11111, "R9 reg0 decode",
          32'({stby_off, spk_on, agc_en, agc_track, gain_boost}), 32'h1F);
    check(agc_attack == 2'd1, "R9 attack field", 32'(agc_attack), 1);
    check(agc_recover == 3'd1, "R9 recover field", 32'(agc_recover), 1);
    check(agc_level == 3'd5, "R2 level field", 32'(agc_level), 5);
    check(test_word == 8'h3C, "R3 third byte to register 2", 32'(test_word), 32'h3C);

    // R6/R7: read stream with wrap; bit 0 of register 0 reads as 0
    read_regs(8'hFE, 8'hA5, 8'h3C, 8'hFE, 4, "R6 read stream (R7 bit0)");

    // R4: nonzero high nibble, no advance
    write_regs(8'h81, 8'h11, 8'h22, 8'h00, 2, "R4 no-advance ack");
    check(agc_level == 3'd1 && agc_recover == 3'd0 && agc_attack == 2'd2, "R4 last byte kept",
          32'({agc_level, agc_recover, agc_attack}), 32'h22);
    check(test_word == 8'h3C, "R4 register 2 untouched", 32'(test_word), 32'h3C);

    // R5: writes past the file are acked and discarded
    write_regs(8'h02, 8'h00, 8'h77, 8'h66, 3, "R5 out-of-range ack");
    write_regs(8'h05, 8'h99, 8'h00, 8'h00, 1, "R5 index 5 ack");
    read_regs(8'hFE, 8'h22, 8'h00, 8'h00, 3, "R5 contents after discard");

    // R1: wrong address gets no ack and following bytes are ignored
    bus_start();
    send_byte(8'hB4, 1'b1, "R1 foreign address nack");
    send_byte(8'h01, 1'b1, "R1 ignored byte");
    send_byte(8'hFF, 1'b1, "R1 ignored byte");
    bus_stop();
    wq();
    check(agc_level == 3'd1 && test_word == 8'h00, "R1 no change after foreign address",
          32'({agc_level, test_word}), 32'h100);

    // R10: STOP inside a data byte
    bus_start();
    send_byte(8'hB6, 1'b0, "R10 address ack");
    send_byte(8'h00, 1'b0, "R10 sub ack");
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop();
    wq();
    check(stby_off == 1'b1 && gain_boost == 1'b1, "R10 partial byte dropped",
          32'({stby_off, gain_boost}), 32'h3);

    // R10: repeated START inside a data byte
    bus_start();
    send_byte(8'hB6, 1'b0, "R10 address ack");
    send_byte(8'h01, 1'b0, "R10 sub ack");
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    bus_start();
    send_byte(8'hB6, 1'b0, "R10 restart address ack");
    send_byte(8'h01, 1'b0, "R10 restart sub ack");
    send_byte(8'h40, 1'b0, "R10 restart data ack");
    bus_stop();
    wq();
    check({agc_level, agc_recover, agc_attack} == 8'h40, "R10 write after restart",
          32'({agc_level, agc_recover, agc_attack}), 32'h40);

    // R8: shutdown clears and blocks writes
    shdn_n = 1'b0;
    repeat (10) @(posedge clk);
    #1;
    check({stby_off, spk_on, agc_en, agc_track, gain_boost, agc_attack, agc_recover,
           agc_level, test_word} == '0, "R8 cleared by shutdown", 32'(test_word), 0);
    write_regs(8'h01, 8'hFF, 8'h00, 8'h00, 1, "R8 ack during shutdown");
    check(agc_level == 3'd0, "R8 write blocked", 32'(agc_level), 0);
    shdn_n = 1'b1;
    wq();
    read_regs(8'h00, 8'h00, 8'h00, 8'h00, 3, "R8 zero after release");

    check(viol == 0, "R11 SDA change while SCL high", 32'(viol), 0);

    check(exp_v.size() == 0, "scoreboard drained", 32'(exp_v.size()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule